// File: doc/BRIEF.md
# Asynchronous SRAM and Non-Volatile Memory Bus Controller

This block connects an internal word-oriented request port to an external asynchronous memory bus. The bus serves two address regions: one holds static RAM and the other non-volatile memory. Each request carries a word address, two byte strobes, a write flag and write data. The block decodes the address into one of the two regions and drives that region's chip select. It then produces output-enable or write-enable strobes around a fixed setup and hold framing. The strobe itself can be stretched by a programmable number of extension clocks, so slow parts work without a slower clock.

Each region is either 8 or 16 bits wide. On an 8-bit region a word access becomes two byte cycles, with the odd (high-order) byte first. The two read bytes are put back together into one word. On an 8-bit region, one bus pin carries byte-address bit 0. On a 16-bit region the same pin is a byte control, and its use depends on the control scheme: with four-wire devices it is the high-byte write strobe, and with five-wire devices it is the upper-byte select, which pairs with a lower-byte-enable output. A request that matches neither region drives nothing on the bus and completes at once with an error flag.

Top module: `asmc_top`

## Requirements
- R1: An address inside [cfg_ram_base, cfg_ram_limit] drives only mem_ram_cs_n low. An address inside [cfg_nv_base, cfg_nv_limit] and not in the RAM range drives only mem_nv_cs_n low. The RAM region wins where the two overlap. The select stays low from the first setup clock to the last hold clock of the access.
- R2: A request in neither region asserts no select and no strobe. It completes with rsp_done and rsp_err high in the clock right after acceptance, with rsp_rdata zero.
- R3: Every byte cycle takes one setup clock, then cfg_ext+1 strobe clocks, then one hold clock. rsp_done rises one clock after the final hold clock, so a single-cycle access completes cfg_ext+3 clocks after acceptance.
- R4: On an 8-bit region, req_be bit 1 selects the odd byte and bit 0 the even byte. Both selected means two byte cycles, odd first. req_be = 00 is treated as 11, on both widths.
- R5: mem_a0_weh carries a different meaning in each mode. On an 8-bit region it carries byte-address bit 0 (1 = odd byte) during the access. On a 16-bit four-wire region it is an active-low high-byte write strobe, asserted only on writes with req_be[1]. On a 16-bit five-wire region it is an active-low upper-byte select, held for the whole access when req_be[1] is set.
- R6: mem_wel_n is low during the strobe clocks of every write to an 8-bit region and of every five-wire write. On a four-wire 16-bit region it goes low only when req_be[0] is set.
- R7: mem_lbe_n is low only on five-wire 16-bit accesses with req_be[0] set, and then for the whole access. It is never low in four-wire mode or on 8-bit regions.
- R8: Reads drive mem_oe_n low during the strobe clocks and sample mem_din at the last strobe clock. On 16-bit regions, bytes not selected read as zero. On 8-bit regions the odd byte (mem_din[7:0]) goes to rsp_rdata[15:8] and the even byte to rsp_rdata[7:0]. Write data is never driven while mem_oe_n is low.
- R9: A strobe falls only after the select has been low for a clock. mem_addr is stable while a select is low. On writes, mem_dout_en, the data and the select stay valid in the clock after mem_wel_n rises. On an 8-bit region the byte on mem_dout[7:0] is the odd or even byte of req_wdata.
- R10: req_ready is high only when no access is in progress. rsp_done is a single-clock pulse.
- R11: cfg_ext (0 to 15) is captured when a request is accepted and sets the strobe length of every byte cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W-1 | Word address |
| req_be | input | 2 | Byte strobes, bit 1 = high/odd byte |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion without a region match |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| cfg_ram_base | input | ADDR_W-1 | First word of the RAM region |
| cfg_ram_limit | input | ADDR_W-1 | Last word of the RAM region |
| cfg_nv_base | input | ADDR_W-1 | First word of the non-volatile region |
| cfg_nv_limit | input | ADDR_W-1 | Last word of the non-volatile region |
| cfg_ram_wide | input | 1 | RAM region is 16 bits wide |
| cfg_nv_wide | input | 1 | Non-volatile region is 16 bits wide |
| cfg_five_wire | input | 1 | 16-bit devices use byte selects (five-wire) |
| cfg_ext | input | EXT_W | Extension clocks per strobe |
| mem_addr | output | ADDR_W-1 | Bus address bits ADDR_W-1 down to 1 |
| mem_ram_cs_n | output | 1 | RAM select, active low |
| mem_nv_cs_n | output | 1 | Non-volatile select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wel_n | output | 1 | Low (or only) byte write enable, active low |
| mem_lbe_n | output | 1 | Lower byte enable, active low |
| mem_a0_weh | output | 1 | Address bit 0 / high write enable / upper byte select |
| mem_dout | output | DATA_W | Write data to the bus |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W | Read data from the bus |

## Verification
The table applies full-word, low-only, high-only and zero-strobe requests to a 16-bit four-wire RAM region and to an 8-bit non-volatile region. It also applies addresses just inside and just outside each region limit, plus an unmapped address. A bus-side memory model stores bytes only on the write-enable edges and the byte selects of the active mode. A dropped or misplaced strobe therefore shows up as wrong read-back data. Counting select and strobe clocks per access separates one byte cycle from two and ties the latency to the extension count. The first strobe's address bit shows which byte goes first. Directed runs at extension 0 and 15, in five-wire mode and with overlapping regions cover the strobe length limits, the upper-byte select and lower-byte-enable behaviour, and RAM priority.

// File: rtl/asmc_pkg.sv
package asmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } asmc_state_e;

    // external control pins, all active low except the shared bit-0 pin in byte mode
    typedef struct packed {
        logic ram_cs_n;
        logic nv_cs_n;
        logic oe_n;
        logic wel_n;
        logic lbe_n;
        logic a0_weh;
    } asmc_pins_t;

    // pin pattern for one clock of a byte cycle
    function automatic asmc_pins_t asmc_pins(
        input logic       active,
        input logic       strobe,
        input logic       we,
        input logic       wide,
        input logic       five,
        input logic       odd,
        input logic       nv,
        input logic [1:0] be
    );
        asmc_pins_t p;
        p = '1;
        if (active) begin
            p.ram_cs_n = nv;
            p.nv_cs_n  = ~nv;
            if (!wide) begin
                p.a0_weh = odd;
                if (strobe) begin
                    if (we) p.wel_n = 1'b0;
                    else    p.oe_n  = 1'b0;
                end
            end else if (five) begin
                p.lbe_n  = ~be[0];
                p.a0_weh = ~be[1];
                if (strobe) begin
                    if (we) p.wel_n = 1'b0;
                    else    p.oe_n  = 1'b0;
                end
            end else begin
                if (strobe) begin
                    if (we) begin
                        p.wel_n  = ~be[0];
                        p.a0_weh = ~be[1];
                    end else begin
                        p.oe_n = 1'b0;
                    end
                end
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/asmc_decode.sv
module asmc_decode #(
    parameter int WA_W = 19,
    parameter int NREG = 2
) (
    input  logic [WA_W-1:0]            addr,
    input  logic [NREG-1:0][WA_W-1:0]  base,
    input  logic [NREG-1:0][WA_W-1:0]  limit,
    output logic [NREG-1:0]            hit
);
    // one inclusive window compare per region
    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign hit[g] = (addr >= base[g]) && (addr <= limit[g]);
    end
endmodule

// File: rtl/asmc_seq.sv
module asmc_seq
    import asmc_pkg::*;
#(
    parameter int WA_W = 19,
    parameter int DW   = 16,
    parameter int EW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_we,
    input  logic [WA_W-1:0] req_addr,
    input  logic [1:0]      req_be,
    input  logic [DW-1:0]   req_wdata,
    input  logic            hit_ram,
    input  logic            hit_nv,
    input  logic            cfg_ram_wide,
    input  logic            cfg_nv_wide,
    input  logic            cfg_five_wire,
    input  logic [EW-1:0]   cfg_ext,
    input  logic [DW-1:0]   mem_din,
    output logic            rsp_done,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic [WA_W-1:0] mem_addr,
    output asmc_pins_t      pins,
    output logic [DW-1:0]   mem_dout,
    output logic            mem_dout_en
);
    localparam int HB = DW / 2;

    typedef struct packed {
        asmc_state_e     st;
        logic [WA_W-1:0] addr;
        logic            we;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            nv;
        logic            wide;
        logic            five;
        logic [EW-1:0]   ext;
        logic [EW-1:0]   cnt;
        logic [1:0]      todo;
        logic            odd;
        asmc_pins_t      pins;
        logic [DW-1:0]   dout;
        logic            dout_en;
        logic            done;
        logic            err;
    } seq_t;

    seq_t       q, d;
    logic [1:0] be_in;
    logic       wide_in;
    logic [1:0] rem;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        be_in   = (req_be == 2'b00) ? 2'b11 : req_be;
        wide_in = hit_ram ? cfg_ram_wide : cfg_nv_wide;
        rem     = (!q.wide && q.odd) ? {1'b0, q.todo[0]} : 2'b00;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit_ram || hit_nv) begin
                        d.st      = ST_SETUP;
                        d.addr    = req_addr;
                        d.we      = req_we;
                        d.wdata   = req_wdata;
                        d.rdata   = '0;
                        d.nv      = !hit_ram;
                        d.wide    = wide_in;
                        d.five    = cfg_five_wire;
                        d.ext     = cfg_ext;
                        d.cnt     = '0;
                        d.todo    = be_in;
                        d.odd     = be_in[1];
                        d.dout_en = req_we;
                        if (wide_in)       d.dout = req_wdata;
                        else if (be_in[1]) d.dout = {{HB{1'b0}}, req_wdata[DW-1:HB]};
                        else               d.dout = {{HB{1'b0}}, req_wdata[HB-1:0]};
                        d.pins = asmc_pins(1'b1, 1'b0, req_we, wide_in, cfg_five_wire,
                                           be_in[1], !hit_ram, be_in);
                    end else begin
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                    end
                end
            end
            ST_SETUP: begin
                d.st   = ST_STROBE;
                d.cnt  = q.ext;
                d.pins = asmc_pins(1'b1, 1'b1, q.we, q.wide, q.five, q.odd, q.nv, q.todo);
            end
            ST_STROBE: begin
                if (q.cnt == '0) begin
                    d.st   = ST_HOLD;
                    d.pins = asmc_pins(1'b1, 1'b0, q.we, q.wide, q.five, q.odd, q.nv, q.todo);
                    if (!q.we) begin
                        if (q.wide)
                            d.rdata = mem_din & {{HB{q.todo[1]}}, {HB{q.todo[0]}}};
                        else if (q.odd)
                            d.rdata[DW-1:HB] = mem_din[HB-1:0];
                        else
                            d.rdata[HB-1:0] = mem_din[HB-1:0];
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (rem != 2'b00) begin
                    d.st   = ST_SETUP;
                    d.todo = rem;
                    d.odd  = 1'b0;
                    d.dout = {{HB{1'b0}}, q.wdata[HB-1:0]};
                    d.pins = asmc_pins(1'b1, 1'b0, q.we, q.wide, q.five, 1'b0, q.nv, rem);
                end else begin
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                    d.todo    = 2'b00;
                    d.dout_en = 1'b0;
                    d.pins    = '1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.pins <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_done    = q.done;
    assign rsp_err     = q.err;
    assign rsp_rdata   = q.rdata;
    assign mem_addr    = q.addr;
    assign pins        = q.pins;
    assign mem_dout    = q.dout;
    assign mem_dout_en = q.dout_en;
endmodule

// File: rtl/asmc_top.sv
module asmc_top
    import asmc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int EXT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-2:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ADDR_W-2:0] cfg_ram_base,
    input  logic [ADDR_W-2:0] cfg_ram_limit,
    input  logic [ADDR_W-2:0] cfg_nv_base,
    input  logic [ADDR_W-2:0] cfg_nv_limit,
    input  logic              cfg_ram_wide,
    input  logic              cfg_nv_wide,
    input  logic              cfg_five_wire,
    input  logic [EXT_W-1:0]  cfg_ext,
    output logic [ADDR_W-1:1] mem_addr,
    output logic              mem_ram_cs_n,
    output logic              mem_nv_cs_n,
    output logic              mem_oe_n,
    output logic              mem_wel_n,
    output logic              mem_lbe_n,
    output logic              mem_a0_weh,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int WA_W = ADDR_W - 1;
    localparam int NREG = 2;

    logic [NREG-1:0]            hit;
    logic [NREG-1:0][WA_W-1:0]  base_v;
    logic [NREG-1:0][WA_W-1:0]  limit_v;
    asmc_pins_t                 pins;
    logic [WA_W-1:0]            addr_w;

    assign base_v  = {cfg_nv_base, cfg_ram_base};
    assign limit_v = {cfg_nv_limit, cfg_ram_limit};

    asmc_decode #(.WA_W(WA_W), .NREG(NREG)) u_dec (
        .addr  (req_addr),
        .base  (base_v),
        .limit (limit_v),
        .hit   (hit)
    );

    asmc_seq #(.WA_W(WA_W), .DW(DATA_W), .EW(EXT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .hit_ram      (hit[0]),
        .hit_nv       (hit[1]),
        .cfg_ram_wide (cfg_ram_wide),
        .cfg_nv_wide  (cfg_nv_wide),
        .cfg_five_wire(cfg_five_wire),
        .cfg_ext      (cfg_ext),
        .mem_din      (mem_din),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .mem_addr     (addr_w),
        .pins         (pins),
        .mem_dout     (mem_dout),
        .mem_dout_en  (mem_dout_en)
    );

    assign mem_addr     = addr_w;
    assign mem_ram_cs_n = pins.ram_cs_n;
    assign mem_nv_cs_n  = pins.nv_cs_n;
    assign mem_oe_n     = pins.oe_n;
    assign mem_wel_n    = pins.wel_n;
    assign mem_lbe_n    = pins.lbe_n;
    assign mem_a0_weh   = pins.a0_weh;
endmodule

// File: rtl/asmc_chk.sv
module asmc_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [ADDR_W-1:1] mem_addr,
    input logic              mem_ram_cs_n,
    input logic              mem_nv_cs_n,
    input logic              mem_oe_n,
    input logic              mem_wel_n,
    input logic              mem_lbe_n,
    input logic              mem_dout_en
);
    logic cs_any;
    assign cs_any = !mem_ram_cs_n || !mem_nv_cs_n;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_ram_cs_n && !mem_nv_cs_n)); // R1
    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> $past(!cs_any)); // R2
    AST_LBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_lbe_n |-> cs_any); // R7
    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_wel_n)); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en); // R8
    AST_SELECT_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_oe_n) || $fell(mem_wel_n)) |-> $past(cs_any)); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any && $past(cs_any)) |-> $stable(mem_addr)); // R9
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wel_n) |-> (cs_any && mem_dout_en)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cs_any && mem_oe_n && mem_wel_n)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10
endmodule

bind asmc_top asmc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .mem_addr    (mem_addr),
    .mem_ram_cs_n(mem_ram_cs_n),
    .mem_nv_cs_n (mem_nv_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_wel_n   (mem_wel_n),
    .mem_lbe_n   (mem_lbe_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sim_asmc_top.sv
module sim_asmc_top;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int EXT_W  = 4;
    localparam int NV = 20;

    // {we, addr[18:0], be[1:0], wdata[15:0], expected rdata[15:0], expected err}
    localparam logic [54:0] VEC [NV] = '{
        {1'b1, 19'h00010, 2'b11, 16'hA1B2, 16'h0000, 1'b0},
        {1'b0, 19'h00010, 2'b11, 16'h0000, 16'hA1B2, 1'b0},
        {1'b1, 19'h00010, 2'b01, 16'h99CC, 16'h0000, 1'b0},
        {1'b0, 19'h00010, 2'b11, 16'h0000, 16'hA1CC, 1'b0},
        {1'b1, 19'h00010, 2'b10, 16'h5533, 16'h0000, 1'b0},
        {1'b0, 19'h00010, 2'b11, 16'h0000, 16'h55CC, 1'b0},
        {1'b0, 19'h00010, 2'b01, 16'h0000, 16'h00CC, 1'b0},
        {1'b1, 19'h40003, 2'b11, 16'h1234, 16'h0000, 1'b0},
        {1'b0, 19'h40003, 2'b11, 16'h0000, 16'h1234, 1'b0},
        {1'b1, 19'h40003, 2'b10, 16'h77AA, 16'h0000, 1'b0},
        {1'b0, 19'h40003, 2'b00, 16'h0000, 16'h7734, 1'b0},
        {1'b0, 19'h40003, 2'b01, 16'h0000, 16'h0034, 1'b0},
        {1'b1, 19'h60000, 2'b11, 16'hFFFF, 16'h0000, 1'b1},
        {1'b0, 19'h60000, 2'b11, 16'h0000, 16'h0000, 1'b1},
        {1'b1, 19'h00020, 2'b00, 16'hCAFE, 16'h0000, 1'b0},
        {1'b0, 19'h00020, 2'b11, 16'h0000, 16'hCAFE, 1'b0},
        {1'b0, 19'h0FFFF, 2'b11, 16'h0000, 16'h0000, 1'b0},
        {1'b0, 19'h10000, 2'b11, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 19'h3FFFF, 2'b11, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 19'h40000, 2'b11, 16'h0000, 16'h0000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-2:0] req_addr = '0;
    logic [1:0]        req_be = 2'b00;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_done, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-2:0] cfg_ram_base = 19'h00000;
    logic [ADDR_W-2:0] cfg_ram_limit = 19'h0FFFF;
    logic [ADDR_W-2:0] cfg_nv_base = 19'h40000;
    logic [ADDR_W-2:0] cfg_nv_limit = 19'h4FFFF;
    logic              cfg_ram_wide = 1'b1;
    logic              cfg_nv_wide = 1'b0;
    logic              cfg_five_wire = 1'b0;
    logic [EXT_W-1:0]  cfg_ext = 4'd2;
    logic [ADDR_W-1:1] mem_addr;
    logic              mem_ram_cs_n, mem_nv_cs_n, mem_oe_n, mem_wel_n, mem_lbe_n, mem_a0_weh;
    logic [DATA_W-1:0] mem_dout;
    logic              mem_dout_en;
    logic [DATA_W-1:0] mem_din;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk; // 4 time units per cycle, 250 MHz

    asmc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_W(EXT_W)) u0 (.*);

    // bus-side memory: 16-bit RAM and 8-bit non-volatile part
    logic [15:0] ram16 [256];
    logic [7:0]  nv8   [512];

    always_comb begin
        mem_din = 16'hDEAD;
        if (!mem_oe_n) begin
            if (!mem_ram_cs_n)     mem_din = ram16[mem_addr[8:1]];
            else if (!mem_nv_cs_n) mem_din = {8'hEE, nv8[{mem_addr[8:1], mem_a0_weh}]};
        end
    end

    // monitor state
    logic mon = 1'b0;
    int   n_ram, n_nv, n_stb, n_bad;
    logic first_seen, first_a0, saw_lbe, saw_ub, saw_wel;
    logic prev_wel = 1'b1, prev_a0 = 1'b1;

    always @(negedge clk) begin
        if (!mem_ram_cs_n) begin
            if (cfg_five_wire) begin
                if (!prev_wel && mem_wel_n) begin
                    if (!mem_dout_en) n_bad++;
                    if (!mem_lbe_n)  ram16[mem_addr[8:1]][7:0]  = mem_dout[7:0];
                    if (!mem_a0_weh) ram16[mem_addr[8:1]][15:8] = mem_dout[15:8];
                end
            end else begin
                if (!prev_wel && mem_wel_n) begin
                    if (!mem_dout_en) n_bad++;
                    ram16[mem_addr[8:1]][7:0] = mem_dout[7:0];
                end
                if (!prev_a0 && mem_a0_weh) begin
                    if (!mem_dout_en) n_bad++;
                    ram16[mem_addr[8:1]][15:8] = mem_dout[15:8];
                end
            end
        end
        if (!mem_nv_cs_n && !prev_wel && mem_wel_n) begin
            if (!mem_dout_en) n_bad++;
            nv8[{mem_addr[8:1], mem_a0_weh}] = mem_dout[7:0];
        end
        if (mon) begin
            if (!mem_ram_cs_n) n_ram++;
            if (!mem_nv_cs_n)  n_nv++;
            if (!mem_oe_n || !mem_wel_n || (!mem_ram_cs_n && !cfg_five_wire && !mem_a0_weh)) begin
                n_stb++;
                if (!first_seen) begin
                    first_seen = 1'b1;
                    first_a0   = mem_a0_weh;
                end
            end
            if (!mem_lbe_n) saw_lbe = 1'b1;
            if (!mem_ram_cs_n && !mem_a0_weh) saw_ub = 1'b1;
            if (!mem_wel_n) saw_wel = 1'b1;
            if (req_ready && (!mem_ram_cs_n || !mem_nv_cs_n)) n_bad++;
            if (!mem_oe_n && mem_dout_en) n_bad++;
        end
        prev_wel = mem_wel_n;
        prev_a0  = mem_a0_weh;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic we, input logic [18:0] addr, input logic [1:0] be,
                           input logic [15:0] wd, output logic [15:0] rd,
                           output logic er, output int lat);
        @(negedge clk);
        n_ram = 0; n_nv = 0; n_stb = 0; n_bad = 0;
        first_seen = 1'b0; first_a0 = 1'b0; saw_lbe = 1'b0; saw_ub = 1'b0; saw_wel = 1'b0;
        chk("R10 ready while idle", {31'd0, req_ready}, 32'd1);
        mon = 1'b1;
        req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
        mon = 1'b0;
        @(negedge clk);
        chk("R10 done is one clock", {31'd0, rsp_done}, 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        er;
        int          lat;
        for (int k = 0; k < 256; k++) ram16[k] = 16'h0000;
        for (int k = 0; k < 512; k++) nv8[k] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R10 reset done", {31'd0, rsp_done}, 32'd0);
        chk("R1 reset selects", {30'd0, mem_ram_cs_n, mem_nv_cs_n}, 32'd3);
        chk("R8 reset strobes", {29'd0, mem_oe_n, mem_wel_n, mem_lbe_n}, 32'd7);
        chk("R9 reset drive", {31'd0, mem_dout_en}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: 16-bit four-wire RAM, 8-bit NV, extension 2
        for (int i = 0; i < NV; i++) begin
            logic        v_we, v_er, in_ram, in_nv;
            logic [18:0] v_ad;
            logic [1:0]  v_be, be_eff;
            logic [15:0] v_wd, v_ex;
            int          nb, exp_lat;
            v_we = VEC[i][54]; v_ad = VEC[i][53:35]; v_be = VEC[i][34:33];
            v_wd = VEC[i][32:17]; v_ex = VEC[i][16:1]; v_er = VEC[i][0];
            be_eff  = (v_be == 2'b00) ? 2'b11 : v_be;
            in_ram  = (v_ad <= 19'h0FFFF);
            in_nv   = !in_ram && (v_ad >= 19'h40000) && (v_ad <= 19'h4FFFF);
            nb      = in_ram ? 1 : (int'(be_eff[1]) + int'(be_eff[0]));
            exp_lat = v_er ? 0 : nb * (int'(cfg_ext) + 3);
            run_req(v_we, v_ad, v_be, v_wd, rd, er, lat);
            chk("R2 error flag", {31'd0, er}, {31'd0, v_er});
            chk("R8 read data", {16'd0, rd}, {16'd0, v_ex});
            chk("R3 latency", lat, exp_lat);
            chk("R1 RAM select clocks", n_ram, in_ram ? exp_lat : 0);
            chk("R1 NV select clocks", n_nv, in_nv ? exp_lat : 0);
            chk("R11 strobe clocks", n_stb, v_er ? 0 : nb * (int'(cfg_ext) + 1));
            chk("R7 no lower byte enable in four-wire", {31'd0, saw_lbe}, 32'd0);
            chk("R6 low write enable use", {31'd0, saw_wel},
                {31'd0, v_we && !v_er && (in_nv || be_eff[0])});
            chk("R9 write hold and drive rules", n_bad, 0);
            if (in_nv) chk("R4 odd byte first", {31'd0, first_a0}, {31'd0, be_eff[1]});
            if (in_ram) chk("R5 high write strobe only on high-byte writes", {31'd0, saw_ub},
                            {31'd0, v_we && be_eff[1]});
        end

        // extension limits
        cfg_ext = 4'd0;
        run_req(1'b0, 19'h00010, 2'b11, 16'h0, rd, er, lat);
        chk("R11 ext 0 latency", lat, 3);
        chk("R8 ext 0 data", {16'd0, rd}, 32'h55CC);
        cfg_ext = 4'd15;
        run_req(1'b0, 19'h40003, 2'b11, 16'h0, rd, er, lat);
        chk("R11 ext 15 latency two byte cycles", lat, 36);
        chk("R4 ext 15 assembled word", {16'd0, rd}, 32'h7734);
        chk("R11 ext 15 strobe clocks", n_stb, 32);

        // five-wire scheme on the RAM region
        cfg_ext = 4'd1;
        cfg_five_wire = 1'b1;
        run_req(1'b1, 19'h00030, 2'b01, 16'h12EE, rd, er, lat);
        chk("R7 lower byte enable on low write", {31'd0, saw_lbe}, 32'd1);
        chk("R5 upper select idle on low write", {31'd0, saw_ub}, 32'd0);
        chk("R6 write enable five-wire", {31'd0, saw_wel}, 32'd1);
        run_req(1'b1, 19'h00030, 2'b10, 16'h11FF, rd, er, lat);
        chk("R7 lower byte enable idle on high write", {31'd0, saw_lbe}, 32'd0);
        chk("R5 upper select on high write", {31'd0, saw_ub}, 32'd1);
        chk("R6 write enable on high-only five-wire write", {31'd0, saw_wel}, 32'd1);
        run_req(1'b0, 19'h00030, 2'b11, 16'h0, rd, er, lat);
        chk("R8 five-wire read back", {16'd0, rd}, 32'h11EE);
        chk("R3 five-wire latency", lat, 4);
        run_req(1'b0, 19'h00030, 2'b01, 16'h0, rd, er, lat);
        chk("R7 lower byte enable on low read", {31'd0, saw_lbe}, 32'd1);
        chk("R8 masked five-wire read", {16'd0, rd}, 32'h00EE);
        cfg_five_wire = 1'b0;

        // overlapping regions: RAM wins
        cfg_nv_base = 19'h00000;
        run_req(1'b0, 19'h00010, 2'b11, 16'h0, rd, er, lat);
        chk("R1 overlap RAM select clocks", n_ram, 4);
        chk("R1 overlap NV select clocks", n_nv, 0);
        chk("R1 overlap data from RAM", {16'd0, rd}, 32'h55CC);
        cfg_nv_base = 19'h40000;

        // single odd byte write to the 8-bit region
        run_req(1'b1, 19'h40005, 2'b10, 16'hAB00, rd, er, lat);
        chk("R4 single odd byte latency", lat, 4);
        run_req(1'b0, 19'h40005, 2'b11, 16'h0, rd, er, lat);
        chk("R9 odd byte taken from high half", {16'd0, rd}, 32'hAB00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule